// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a four-channel serial DAC and turns one command into one complete write on a three-wire serial link, with an optional pulse on the DAC's active-low load strobe afterwards. A command carries a two-bit channel number, a data word, two power-down flags and a frame-size choice. The power-down flags are a global "all channels off" flag and a "selected channel off" flag. The frame-size choice is either the long form (12 data bits) or the short form (10 data bits). The block packs these fields into a 16-bit word and shifts it out most significant bit first. Data changes while the serial clock is low, so the DAC can sample it on the rising edge.

The DAC's analog timing minimums are given as nanosecond parameters. These cover chip-select setup and hold, clock high and low time, the minimum clock period, load pulse width and load hold after chip select. The block converts each one to a whole number of system-clock cycles, always rounding up. A `busy` level and a one-cycle `done` pulse let the issuing logic pace its commands. Commands are taken only while the block is idle.

Top module: `dac_serial_seq`

## Requirements
- R1: In the long frame the 16 bits leave `dac_sdi` in this order: all-off flag, channel-off flag, `cmd_chan[1]`, `cmd_chan[0]`, then `cmd_data[11:0]` from bit 11 down to bit 0. `dac_sdi` changes only while `dac_sck` is low.
- R2: When `cmd_short` is 1, the frame is still 16 clocks long. It starts with two pad bits driven as 0, followed by all-off flag, channel-off flag, `cmd_chan[1]`, `cmd_chan[0]` and `cmd_data[9:0]` from bit 9 down to bit 0.
- R3: `dac_cs_n` goes low in the cycle after a command is accepted. It stays low for exactly 16 rising edges of `dac_sck`.
- R4: `dac_sck` is low whenever `dac_cs_n` is high. Each high phase lasts 3 cycles and each low phase between bits lasts 3 cycles. These are the defaults: 45 ns rounded up at 20 ns, with the low phase stretched where needed to respect the minimum clock period.
- R5: The first rising edge of `dac_sck` comes 3 cycles after `dac_cs_n` falls. This count is the larger of the chip-select setup count and the clock-low count.
- R6: `dac_cs_n` returns high 1 cycle after the last falling edge of `dac_sck` (the default hold count). That is 4 cycles after the last rising edge.
- R7: When `cmd_load` was set with the command, `dac_ld_n` falls on the same edge that raises `dac_cs_n`. It stays low for 3 cycles, the larger of the pulse-width and hold counts. Without `cmd_load` it stays high. It is never low while `dac_cs_n` is low.
- R8: `done` is high for exactly one cycle. It comes in the second cycle after the last of these events: `dac_cs_n` rising when no strobe was requested, or `dac_ld_n` rising when one was.
- R9: `busy` is high from the cycle after acceptance through the cycle before `done`, and low in the `done` cycle. A command is accepted at a rising edge only when `busy` is low and `cmd_valid` is high. Commands and field changes while `busy` is high have no effect. A command presented during the `done` cycle is accepted.
- R10: After reset, `dac_cs_n`=1, `dac_sck`=0, `dac_sdi`=0, `dac_ld_n`=1, `done`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_chan | input | 2 | Target channel number |
| cmd_data | input | DATA_W | Data word (low 10 bits used in short frames) |
| cmd_all_off | input | 1 | Power down all channels |
| cmd_chan_off | input | 1 | Power down the addressed channel |
| cmd_short | input | 1 | 1: short frame with two leading pad bits |
| cmd_load | input | 1 | Pulse the load strobe after the frame |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sck | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data to the DAC |
| dac_ld_n | output | 1 | Active-low load strobe |

## Verification
The completion pulse and the acceptance of the next command can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by raising `cmd_valid` early and holding it there. While the first write runs it changes the command fields, and it lets `cmd_valid` drop only after the `done` cycle. The reference model must see the first write's frame unaltered, then a second frame carrying the changed fields starting right after the `done` cycle, and exactly two `done` pulses in total.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_STROBE,
        ST_FIN
    } seq_state_e;

    // Whole cycles covering t_ns at a clock period of per_ns, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int per_ns);
        int c;
        c = (t_ns + per_ns - 1) / per_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dss_frame_pack.sv
module dss_frame_pack #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = DATA_W + 4
) (
    input  logic [1:0]         chan,
    input  logic [DATA_W-1:0]  data,
    input  logic               all_off,
    input  logic               chan_off,
    input  logic               short_sel,
    output logic [FRAME_W-1:0] frame
);
    localparam int SHORT_W = DATA_W - 2;

    logic [FRAME_W-1:0] long_word;
    logic [FRAME_W-1:0] short_word;

    // Control field first, data word last, so the control bits lead on the wire.
    assign long_word  = {all_off, chan_off, chan, data};
    assign short_word = {2'b00, all_off, chan_off, chan, data[SHORT_W-1:0]};

    always_comb begin
        frame = short_sel ? short_word : long_word;
    end

endmodule

// File: rtl/dss_timer.sv
module dss_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_serial_seq.sv
module dac_serial_seq
    import dss_pkg::*;
#(
    parameter int SYS_CLK_NS   = 20,
    parameter int DATA_W       = 12,
    parameter int T_CSS_NS     = 10,
    parameter int T_CH_NS      = 45,
    parameter int T_CL_NS      = 45,
    parameter int T_SCK_MIN_NS = 91,
    parameter int T_CSH_NS     = 20,
    parameter int T_LDW_NS     = 45,
    parameter int T_LDH_NS     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_chan,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_all_off,
    input  logic              cmd_chan_off,
    input  logic              cmd_short,
    input  logic              cmd_load,
    output logic              busy,
    output logic              done,
    output logic              dac_cs_n,
    output logic              dac_sck,
    output logic              dac_sdi,
    output logic              dac_ld_n
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    // Phase lengths in system cycles, all rounded up.
    localparam int CSS_C   = ns_to_cycles(T_CSS_NS, SYS_CLK_NS);
    localparam int CH_C    = ns_to_cycles(T_CH_NS, SYS_CLK_NS);
    localparam int CL_RAW  = ns_to_cycles(T_CL_NS, SYS_CLK_NS);
    localparam int PER_C   = ns_to_cycles(T_SCK_MIN_NS, SYS_CLK_NS);
    localparam int CL_C    = imax(CL_RAW, PER_C - CH_C);
    localparam int SETUP_C = imax(CSS_C, CL_C);
    localparam int CSH_C   = ns_to_cycles(T_CSH_NS, SYS_CLK_NS);
    localparam int LD_C    = imax(ns_to_cycles(T_LDW_NS, SYS_CLK_NS),
                                  ns_to_cycles(T_LDH_NS, SYS_CLK_NS));
    localparam int MAX_C   = imax(imax(SETUP_C, CH_C), imax(imax(CL_C, CSH_C), LD_C));
    localparam int TMR_W   = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [FRAME_W-1:0] shreg;
        logic [BIT_W-1:0]   bits_left;
        logic               cs_n;
        logic               sck;
        logic               sdo;
        logic               ld_n;
        logic               done;
        logic               ld_req;
    } seq_t;

    seq_t s_d, s_q;

    logic [FRAME_W-1:0] frame;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_zero;

    dss_frame_pack #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_pack (
        .chan      (cmd_chan),
        .data      (cmd_data),
        .all_off   (cmd_all_off),
        .chan_off  (cmd_chan_off),
        .short_sel (cmd_short),
        .frame     (frame)
    );

    dss_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.st        = ST_SETUP;
                    s_d.cs_n      = 1'b0;
                    s_d.sdo       = frame[FRAME_W-1];
                    s_d.shreg     = frame << 1;
                    s_d.bits_left = BIT_W'(FRAME_W);
                    s_d.ld_req    = cmd_load;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(SETUP_C - 1);
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tmr_zero) begin
                    s_d.st        = ST_HIGH;
                    s_d.sck       = 1'b1;
                    s_d.bits_left = s_q.bits_left - 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(CH_C - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    s_d.sck  = 1'b0;
                    tmr_load = 1'b1;
                    if (s_q.bits_left == '0) begin
                        s_d.st  = ST_HOLD;
                        tmr_val = TMR_W'(CSH_C - 1);
                    end else begin
                        s_d.st    = ST_LOW;
                        s_d.sdo   = s_q.shreg[FRAME_W-1];
                        s_d.shreg = s_q.shreg << 1;
                        tmr_val   = TMR_W'(CL_C - 1);
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    s_d.cs_n = 1'b1;
                    if (s_q.ld_req) begin
                        s_d.st   = ST_STROBE;
                        s_d.ld_n = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(LD_C - 1);
                    end else begin
                        s_d.st = ST_FIN;
                    end
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    s_d.st   = ST_FIN;
                    s_d.ld_n = 1'b1;
                end
            end
            ST_FIN: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st        <= ST_IDLE;
            s_q.shreg     <= '0;
            s_q.bits_left <= '0;
            s_q.cs_n      <= 1'b1;
            s_q.sck       <= 1'b0;
            s_q.sdo       <= 1'b0;
            s_q.ld_n      <= 1'b1;
            s_q.done      <= 1'b0;
            s_q.ld_req    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign dac_cs_n = s_q.cs_n;
    assign dac_sck  = s_q.sck;
    assign dac_sdi  = s_q.sdo;
    assign dac_ld_n = s_q.ld_n;

endmodule

// File: rtl/dss_checks.sv
module dss_checks #(
    parameter int FRAME_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic sdo,
    input logic ld_n,
    input logic done,
    input logic busy
);
    logic       cs_n_prev, sck_prev;
    logic [7:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_prev <= 1'b1;
            sck_prev  <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            cs_n_prev <= cs_n;
            sck_prev  <= sck;
            if (cs_n_prev && !cs_n)     rise_cnt <= '0;
            else if (!sck_prev && sck)  rise_cnt <= rise_cnt + 8'd1;
        end
    end

    a_r3_sixteen_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 8'(FRAME_W)));

    a_r3_select_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> busy);

    a_r4_clock_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r1_data_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdo));

    a_r7_strobe_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |-> cs_n);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && ld_n));

endmodule

bind dac_serial_seq dss_checks #(.FRAME_W(FRAME_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (dac_cs_n),
    .sck   (dac_sck),
    .sdo   (dac_sdi),
    .ld_n  (dac_ld_n),
    .done  (done),
    .busy  (busy)
);

// File: tb/dac_serial_seq_test.sv
module dac_serial_seq_test;

    // Phase lengths from the requirements at the default parameters.
    localparam int SETUP_N = 3;   // R5
    localparam int HI_N    = 3;   // R4
    localparam int LO_N    = 3;   // R4
    localparam int CSH_N   = 1;   // R6
    localparam int LD_N    = 3;   // R7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_chan = '0;
    logic [11:0] cmd_data = '0;
    logic        cmd_all_off = 1'b0;
    logic        cmd_chan_off = 1'b0;
    logic        cmd_short = 1'b0;
    logic        cmd_load = 1'b0;
    logic        busy, done, dac_cs_n, dac_sck, dac_sdi, dac_ld_n;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dac_serial_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_chan     (cmd_chan),
        .cmd_data     (cmd_data),
        .cmd_all_off  (cmd_all_off),
        .cmd_chan_off (cmd_chan_off),
        .cmd_short    (cmd_short),
        .cmd_load     (cmd_load),
        .busy         (busy),
        .done         (done),
        .dac_cs_n     (dac_cs_n),
        .dac_sck      (dac_sck),
        .dac_sdi      (dac_sdi),
        .dac_ld_n     (dac_ld_n)
    );

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sdo;
        logic chk_sdo;
        logic ld_n;
        logic done;
        logic busy;
    } exp_t;

    exp_t expq[$];
    exp_t cur;

    function automatic exp_t mk(logic c, logic k, logic d, logic chk, logic l, logic dn, logic b);
        exp_t e;
        e.cs_n = c; e.sck = k; e.sdo = d; e.chk_sdo = chk;
        e.ld_n = l; e.done = dn; e.busy = b;
        return e;
    endfunction

    // Expected waveform of one write, one entry per cycle after acceptance.
    task automatic build_frame();
        logic [15:0] w;
        if (cmd_short) w = {2'b00, cmd_all_off, cmd_chan_off, cmd_chan, cmd_data[9:0]}; // R2
        else           w = {cmd_all_off, cmd_chan_off, cmd_chan, cmd_data};             // R1
        for (int k = 0; k < SETUP_N; k++) expq.push_back(mk(0, 0, w[15], 1, 1, 0, 1));
        for (int i = 15; i >= 0; i--) begin
            for (int k = 0; k < HI_N; k++) expq.push_back(mk(0, 1, w[i], 1, 1, 0, 1));
            if (i > 0)
                for (int k = 0; k < LO_N; k++) expq.push_back(mk(0, 0, w[i-1], 1, 1, 0, 1));
        end
        for (int k = 0; k < CSH_N; k++) expq.push_back(mk(0, 0, w[0], 1, 1, 0, 1));
        if (cmd_load)
            for (int k = 0; k < LD_N; k++) expq.push_back(mk(1, 0, 0, 0, 0, 0, 1));
        expq.push_back(mk(1, 0, 0, 0, 1, 0, 1));
        expq.push_back(mk(1, 0, 0, 0, 1, 1, 0));
    endtask

    // Reference model: advances once per rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expq.delete();
            cur = mk(1, 0, 0, 1, 1, 0, 0);
        end else begin
            if (!cur.busy && cmd_valid) begin
                build_frame();
                cur = expq.pop_front();
            end else if (expq.size() > 0) begin
                cur = expq.pop_front();
            end else begin
                cur = mk(1, 0, 0, 0, 1, 0, 0);
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 R6 cs_n", dac_cs_n, cur.cs_n);
            check("R4 R5 sck", dac_sck, cur.sck);
            if (cur.chk_sdo) check("R1 R2 sdi", dac_sdi, cur.sdo);
            check("R7 ld_n", dac_ld_n, cur.ld_n);
            check("R8 done", done, cur.done);
            check("R9 busy", busy, cur.busy);
            if (done) done_cnt++;
        end
    end

    task automatic send(logic [1:0] ch, logic [11:0] d, logic sa, logic sd, logic sh, logic ld);
        @(negedge clk);
        cmd_chan = ch; cmd_data = d; cmd_all_off = sa; cmd_chan_off = sd;
        cmd_short = sh; cmd_load = ld; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R10: reset values
        repeat (3) @(negedge clk);
        check("R10 cs_n", dac_cs_n, 1'b1);
        check("R10 sck", dac_sck, 1'b0);
        check("R10 sdi", dac_sdi, 1'b0);
        check("R10 ld_n", dac_ld_n, 1'b1);
        check("R10 done", done, 1'b0);
        check("R10 busy", busy, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 long frame, no strobe
        send(2'd2, 12'hA5C, 1'b0, 1'b0, 1'b0, 1'b0); wait_idle();
        // R7 long frame, strobe, channel power-down flag
        send(2'd1, 12'h3C7, 1'b0, 1'b1, 1'b0, 1'b1); wait_idle();
        // R2 short frame, global power-down flag, strobe
        send(2'd3, 12'hEB3, 1'b1, 1'b0, 1'b1, 1'b1); wait_idle();
        // R1 extreme patterns
        send(2'd0, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0); wait_idle();
        send(2'd0, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0); wait_idle();

        // R9 R8: fields change while busy, valid held into the done cycle
        done_cnt = 0;
        @(negedge clk);
        cmd_chan = 2'd1; cmd_data = 12'h5A3; cmd_all_off = 0; cmd_chan_off = 0;
        cmd_short = 0; cmd_load = 1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_chan = 2'd2; cmd_data = 12'h1E6; cmd_short = 1; cmd_load = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        n_cmp++;
        if (done_cnt != 2) begin
            n_bad++;
            $display("FAIL R8 done pulses: actual %0d expected 2", done_cnt);
        end

        finish_run();
    end

endmodule